// File: doc/BRIEF.md
# Frame CRC Generator and Checker

This block keeps a 32-bit cyclic redundancy check over the payload Dwords of a serial storage link frame, one whole Dword per clock. The frame is bounded by a start marker and an end marker carried on the same stream. Dwords flagged as primitives are never folded in, and neither are the marker Dwords. The running value is seeded with the constant 0x52325032 at every start marker. The stream is unscrambled data: on transmit the block sits ahead of the scrambler, and on receive it sits after the descrambler.

On the transmit side the running value, read after the last payload Dword, is the Dword to send just ahead of the end marker. On the receive side the last non-primitive Dword before the end marker is the received check word. It is compared with the running value taken over the payload ahead of it, and the verdict is given as a one-cycle pulse.

A three-state controller follows the frame: `ST_IDLE` (outside a frame), `ST_OPEN` (start seen, no payload yet) and `ST_BODY` (at least one payload Dword seen). Its transitions are:

- `T_START`: from any state to `ST_OPEN` when a start marker arrives.
- `T_FIRST`: from `ST_OPEN` to `ST_BODY` when the first data Dword arrives.
- `T_MORE`: from `ST_BODY` back to itself when a further data Dword arrives.
- `T_END_EMPTY`: from `ST_OPEN` to `ST_IDLE` when an end marker arrives.
- `T_END_CHECK`: from `ST_BODY` to `ST_IDLE` when an end marker arrives.

Any other input leaves the state where it is.

Top module: `frame_crc_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `crc_value` is 0x52325032 and `frame_done` and `crc_err` are 0.
- R2: A Dword with `in_valid`=1, `in_prim`=0, `in_sof`=0 and `in_eof`=0 that arrives inside a frame is folded in. In the next cycle `crc_value` equals the old value advanced by the 32 data bits. The generator polynomial is 0x04C11DB7, data bit 31 goes in first, the input and the output are not bit-reflected, and there is no final XOR.
- R3: A Dword with `in_valid`=1 and `in_sof`=1 restarts the frame in any state. In the next cycle `crc_value` is 0x52325032, and that Dword is not folded in. `in_sof` takes priority over `in_eof`.
- R4: Inside a frame, a cycle with `in_valid`=0, or with `in_prim`=1 and neither marker, leaves `crc_value` unchanged.
- R5: An end marker (`in_valid`=1, `in_eof`=1, `in_sof`=0) that follows at least one data Dword raises `frame_done` for exactly one cycle, one cycle later. In that cycle `crc_err` is 1 exactly when the last data Dword differs from the CRC taken over the data Dwords ahead of it.
- R6: An end marker with no data Dword since the start marker raises `frame_done` and `crc_err` together, for one cycle.
- R7: Outside a frame (after reset, or after an end marker), data Dwords and end markers are ignored: `crc_value` does not change and `frame_done` stays 0.
- R8: `crc_err` is never 1 unless `frame_done` is 1.
- R9: The end marker does not change `crc_value`, so the transmit side can still read the check value after the frame has closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A Dword is present this cycle |
| in_data | input | 32 | Dword value |
| in_prim | input | 1 | The Dword is a primitive |
| in_sof | input | 1 | The Dword is the start-of-frame marker |
| in_eof | input | 1 | The Dword is the end-of-frame marker |
| crc_value | output | 32 | Running CRC over the payload since the last start marker |
| frame_done | output | 1 | One-cycle pulse: the receive check finished |
| crc_err | output | 1 | With `frame_done`: the check failed |

## Verification
The hardest case to reach from the ports is a verdict that depends on the snapshot taken one payload Dword ahead of the end marker, after primitives have been slipped in between the payload Dwords. A frame built that way only passes if each skipped primitive leaves the snapshot untouched. The stimulus builds receive frames in the bench: it computes the check word from its own model of the polynomial, inserts primitives and idle cycles between the payload Dwords, and then sends either the correct check word or one with a single bit flipped. Two further frames cover the edges: a frame whose only Dword is the check word, which must equal the seed, and a frame with no Dword at all between its markers.

// File: rtl/frame_crc_pkg.sv
package frame_crc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_BODY = 2'd2
    } frm_state_t;

endpackage

// File: rtl/crc_dword_step.sv
module crc_dword_step #(
    parameter int          W    = 32,
    parameter logic [31:0] POLY = 32'h04C11DB7
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] word,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] GEN = POLY[W-1:0];

    always_comb begin
        logic [W-1:0] acc;
        acc = cur;
        for (int b = W - 1; b >= 0; b--) begin
            if (acc[W-1] ^ word[b]) begin
                acc = {acc[W-2:0], 1'b0} ^ GEN;
            end else begin
                acc = {acc[W-2:0], 1'b0};
            end
        end
        nxt = acc;
    end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import frame_crc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_prim,
    input  logic in_sof,
    input  logic in_eof,
    output logic do_load,
    output logic do_fold,
    output logic do_check,
    output logic do_empty
);
    frm_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        do_load  = 1'b0;
        do_fold  = 1'b0;
        do_check = 1'b0;
        do_empty = 1'b0;
        if (in_valid && in_sof) begin
            do_load  = 1'b1;
            state_nx = ST_OPEN;
        end else if (in_valid) begin
            unique case (state)
                ST_IDLE: begin
                    state_nx = ST_IDLE;
                end
                ST_OPEN: begin
                    if (in_eof) begin
                        do_empty = 1'b1;
                        state_nx = ST_IDLE;
                    end else if (!in_prim) begin
                        do_fold  = 1'b1;
                        state_nx = ST_BODY;
                    end
                end
                ST_BODY: begin
                    if (in_eof) begin
                        do_check = 1'b1;
                        state_nx = ST_IDLE;
                    end else if (!in_prim) begin
                        do_fold  = 1'b1;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/crc_track.sv
module crc_track #(
    parameter int          W    = 32,
    parameter logic [31:0] SEED = 32'h52325032,
    parameter logic [31:0] POLY = 32'h04C11DB7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word,
    input  logic         do_load,
    input  logic         do_fold,
    input  logic         do_check,
    input  logic         do_empty,
    output logic [W-1:0] run_crc,
    output logic         done_q,
    output logic         err_q
);
    localparam logic [W-1:0] INIT = SEED[W-1:0];

    logic [W-1:0] prev_crc;
    logic [W-1:0] last_word;
    logic [W-1:0] next_crc;

    crc_dword_step #(.W(W), .POLY(POLY)) u_step (
        .cur  (run_crc),
        .word (word),
        .nxt  (next_crc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_crc   <= INIT;
            prev_crc  <= INIT;
            last_word <= '0;
        end else if (do_load) begin
            run_crc   <= INIT;
            prev_crc  <= INIT;
            last_word <= '0;
        end else if (do_fold) begin
            prev_crc  <= run_crc;
            run_crc   <= next_crc;
            last_word <= word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= do_check | do_empty;
            err_q  <= do_empty | (do_check & (last_word != prev_crc));
        end
    end
endmodule

// File: rtl/frame_crc_unit.sv
module frame_crc_unit #(
    parameter int          W    = 32,
    parameter logic [31:0] SEED = 32'h52325032,
    parameter logic [31:0] POLY = 32'h04C11DB7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [31:0]  in_data,
    input  logic         in_prim,
    input  logic         in_sof,
    input  logic         in_eof,
    output logic [31:0]  crc_value,
    output logic         frame_done,
    output logic         crc_err
);
    logic do_load, do_fold, do_check, do_empty;
    logic [W-1:0] run_crc;

    frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_prim  (in_prim),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .do_load  (do_load),
        .do_fold  (do_fold),
        .do_check (do_check),
        .do_empty (do_empty)
    );

    crc_track #(.W(W), .SEED(SEED), .POLY(POLY)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .word     (in_data[W-1:0]),
        .do_load  (do_load),
        .do_fold  (do_fold),
        .do_check (do_check),
        .do_empty (do_empty),
        .run_crc  (run_crc),
        .done_q   (frame_done),
        .err_q    (crc_err)
    );

    assign crc_value = run_crc;
endmodule

// File: rtl/frame_crc_checker.sv
module frame_crc_checker #(
    parameter logic [31:0] SEED = 32'h52325032
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_prim,
    input logic        in_sof,
    input logic        in_eof,
    input logic [31:0] crc_value,
    input logic        frame_done,
    input logic        crc_err
);
    assert_err_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> frame_done);

    assert_done_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_start_reseeds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> (crc_value == SEED));

    assert_prim_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_prim && !in_sof) |=> $stable(crc_value));

    assert_gap_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(crc_value));

    assert_end_keeps_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof && !in_sof) |=> $stable(crc_value));

    assert_done_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(in_valid && in_eof && !in_sof));
endmodule

bind frame_crc_unit frame_crc_checker #(.SEED(SEED)) u_crc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_prim    (in_prim),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .crc_value  (crc_value),
    .frame_done (frame_done),
    .crc_err    (crc_err)
);

// File: tb/test_frame_crc_unit.sv
module test_frame_crc_unit;
    localparam logic [31:0] SEED = 32'h52325032;
    localparam logic [31:0] GEN  = 32'h04C11DB7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_prim = 1'b0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic [31:0] crc_value;
    logic        frame_done;
    logic        crc_err;

    int checks = 0;
    int errors = 0;
    bit expq[$];

    always #4 clk = ~clk;

    frame_crc_unit i_frame_crc_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_prim(in_prim), .in_sof(in_sof), .in_eof(in_eof),
        .crc_value(crc_value), .frame_done(frame_done), .crc_err(crc_err)
    );

    function automatic logic [31:0] model_step(logic [31:0] c, logic [31:0] d);
        logic [31:0] r;
        r = c;
        for (int k = 0; k < 32; k++) begin
            logic fb;
            fb = r[31] ^ d[31-k];
            r  = r << 1;
            if (fb) r = r ^ GEN;
        end
        return r;
    endfunction

    task automatic check_word(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic drive(logic v, logic [31:0] d, logic p, logic s, logic e);
        @(negedge clk);
        in_valid = v; in_data = d; in_prim = p; in_sof = s; in_eof = e;
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_prim = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic send_sof();
        drive(1'b1, 32'h7C37_B5B5, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic send_data(logic [31:0] d);
        drive(1'b1, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic send_prim();
        drive(1'b1, 32'h7C95_AAAA, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic send_eof(bit exp_err);
        expq.push_back(exp_err);
        drive(1'b1, 32'h7CD5_B5B5, 1'b1, 1'b0, 1'b1);
    endtask

    // monitor: pops expected verdicts as pulses appear
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                if (frame_done) begin
                    checks++;
                    if (expq.size() == 0) begin
                        errors++;
                        $display("FAIL R7: actual frame_done=1 expected=0");
                    end else begin
                        bit e;
                        e = expq.pop_front();
                        if (crc_err !== e) begin
                            errors++;
                            $display("FAIL R5/R6: actual crc_err=%0b expected=%0b", crc_err, e);
                        end
                    end
                end else if (crc_err) begin
                    checks++;
                    errors++;
                    $display("FAIL R8: actual crc_err=1 expected=0 without frame_done");
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] c;
        logic [31:0] held;

        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check_word("R1 crc during reset", crc_value, SEED);
        check_word("R1 done during reset", {31'd0, frame_done}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_word("R1 crc after reset", crc_value, SEED);
        check_word("R1 err after reset", {31'd0, crc_err}, 32'd0);

        // R7 data and end outside a frame ignored
        send_data(32'hDEAD_BEEF);
        check_word("R7 data outside frame", crc_value, SEED);
        drive(1'b1, 32'h7CD5_B5B5, 1'b1, 1'b0, 1'b1);
        check_word("R7 end outside frame", crc_value, SEED);

        // R2 transmit: fold three payload Dwords
        send_sof();
        check_word("R3 seed at start", crc_value, SEED);
        c = SEED;
        for (int i = 0; i < 3; i++) begin
            logic [31:0] w;
            w = 32'h1111_1111 * (i + 1) ^ 32'h0F0F_00FF;
            send_data(w);
            c = model_step(c, w);
            check_word("R2 running crc", crc_value, c);
        end
        send_eof(1'b1);
        check_word("R9 end keeps crc", crc_value, c);

        // R5 receive good frame with primitives and gaps
        send_sof();
        c = SEED;
        send_data(32'h0000_0000); c = model_step(c, 32'h0000_0000);
        held = crc_value;
        send_prim();
        check_word("R4 primitive mid-frame", crc_value, held);
        drive(1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
        check_word("R4 idle cycle mid-frame", crc_value, held);
        send_data(32'hFFFF_FFFF); c = model_step(c, 32'hFFFF_FFFF);
        send_prim();
        send_data(32'hA5A5_5A5A); c = model_step(c, 32'hA5A5_5A5A);
        check_word("R2 crc after mixed", crc_value, c);
        send_data(c);
        send_eof(1'b0);

        // R5 receive bad frame: one flipped bit
        send_sof();
        c = SEED;
        send_data(32'h1234_5678); c = model_step(c, 32'h1234_5678);
        send_data(32'h9ABC_DEF0); c = model_step(c, 32'h9ABC_DEF0);
        send_prim();
        send_data(c ^ 32'h0000_0100);
        send_eof(1'b1);

        // R5 frame holding only the check word: must equal seed
        send_sof();
        send_data(SEED);
        send_eof(1'b0);

        // R6 empty frame
        send_sof();
        send_prim();
        send_eof(1'b1);

        // R3 restart mid-frame, then a good frame
        send_sof();
        send_data(32'h5555_AAAA);
        send_sof();
        check_word("R3 restart mid-frame", crc_value, SEED);
        c = model_step(SEED, 32'h0BAD_F00D);
        send_data(32'h0BAD_F00D);
        send_data(c);
        send_eof(1'b0);

        repeat (4) @(posedge clk);
        #3;
        check_word("R5 all verdicts seen", expq.size(), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule